// File: doc/BRIEF.md
# Clock-Stop Power State Controller

This block runs on the bus clock and follows a processor-style low-power state machine with four states: Normal, Stop-Grant, Grant-Snoop and Sleep. Active-low stop-clock and sleep requests move it between the states. A snoop or interrupt transaction seen on the bus while the clock is stopped moves it to Grant-Snoop. It returns to Stop-Grant when the transaction reports completion.

Five asynchronous event requests can arrive while the core is stopped: bus-init, init, system-management and two local interrupt lines. The block holds each of these in a latch and does not service them until Normal resumes. It then releases them as single-cycle service pulses, one per cycle, in a fixed priority order. Repeated arrivals of one source collapse into one pulse. An interrupt delivered by a bus transaction is also latched. It is released only when the interrupt-enable input is high.

A low-active break-event output tells system logic that an interrupt is pending, whether or not that interrupt is masked. Misuse of the sleep and snoop protocol raises a one-cycle error pulse with a cause code.

Top module: `cstop_ctrl`

## Requirements
- R1: All inputs are sampled on the rising clock edge. While `rst_n` is low, the latches, service pulses and error output are cleared. The state becomes Stop-Grant if `stpclk_n` is low, otherwise Normal. The state code on `pm_state` is 00 Normal, 01 Stop-Grant, 10 Grant-Snoop, 11 Sleep.
- R2: From Normal, a sampled low `stpclk_n` moves the state to Stop-Grant at that edge. From Stop-Grant, a high `stpclk_n` returns it to Normal. This check takes precedence over the other Stop-Grant exits.
- R3: In Stop-Grant with `stpclk_n` low, a low `snoop_n` moves the state to Grant-Snoop. The state stays in Grant-Snoop until `snp_done` is sampled high, and then returns to Stop-Grant.
- R4: In Stop-Grant, a low `slp_n` with `all_sg` high and no snoop moves the state to Sleep. A high `slp_n` in Sleep returns the state to Stop-Grant. A low `slp_n` with `all_sg` low leaves the state in Stop-Grant and raises error cause 1.
- R5: A low `slp_n` sampled in Normal or in Grant-Snoop raises error cause 1.
- R6: A high `slp_n` in the first cycle after Sleep was entered means the sleep request was too short. It raises error cause 2.
- R7: A high `stpclk_n` sampled in Sleep raises error cause 3. This includes the edge at which `slp_n` is released, so stop-clock must be released at least one clock after sleep.
- R8: A low `snoop_n` sampled in Sleep raises error cause 4. So does a low `snoop_n` sampled in Stop-Grant together with a low `slp_n`, and in that case the state goes to Grant-Snoop. When several causes apply, the highest code is reported.
- R9: Event requests on `evt_req` are latched in every state. Service pulses leave only when the state register holds Normal. Any number of arrivals of one source produce one pulse. An arrival in the same cycle as its own pulse re-latches that source.
- R10: Service pulses appear on `svc` one per cycle, starting one edge after Normal is reached, and each clears its latch. The bit order is [4] bus-init, [3] init, [2] system-management, [1] local interrupt 1, [0] local interrupt 0, and the highest bit goes first.
- R11: A bus interrupt is latched when `snp_done` and `bus_intr` are sampled high in Grant-Snoop. `pbe_n` is low whenever this latch or either local-interrupt latch is set, whatever the value of `int_en`.
- R12: The latched bus interrupt leaves as a `svc_intr` pulse in Normal, but only when `int_en` is high and no `evt_req` latch is pending. While `int_en` is low it stays pending.
- R13: `err` and `err_cause` are registered. They show the violation one edge after the offending sample and last one cycle unless the violation repeats. With no violation, `err_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| stpclk_n | input | 1 | Active-low stop-clock request |
| slp_n | input | 1 | Active-low sleep request |
| snoop_n | input | 1 | Active-low snoop or interrupt transaction in progress |
| snp_done | input | 1 | Snoop serviced or interrupt accepted |
| bus_intr | input | 1 | Current transaction delivers an interrupt |
| all_sg | input | 1 | Every logical thread is in Stop-Grant |
| int_en | input | 1 | Interrupt-enable flag of the core |
| evt_req | input | 5 | Event requests: bus-init, init, system-management, local 1, local 0 |
| svc | output | 5 | One-cycle service pulses, same bit order |
| svc_intr | output | 1 | One-cycle service pulse for the bus interrupt |
| pbe_n | output | 1 | Active-low pending break event |
| err | output | 1 | Protocol violation pulse |
| err_cause | output | 3 | Violation cause code (0 none, 1 to 4) |
| pm_state | output | 2 | Current state code |

## Verification
Two functions can act on the same latch in one cycle: a source can arrive at the edge where its earlier latch is being drained. That must give a second pulse and no lost event. The bench provokes this with a directed back-to-back request and with random event traffic during Normal. A state transition and a violation can also coincide: a snoop together with a sleep request in Stop-Grant must enter Grant-Snoop and report cause 4. Random stimulus hits this case often. A reference model in the bench judges every cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'b00,
    ST_SGNT = 2'b01,
    ST_GSNP = 2'b10,
    ST_SLP  = 2'b11
  } pm_state_e;

  typedef enum logic [2:0] {
    EC_NONE       = 3'd0,
    EC_SLP_STATE  = 3'd1,
    EC_SLP_SHORT  = 3'd2,
    EC_EXIT_ORDER = 3'd3,
    EC_SNP_SLEEP  = 3'd4
  } err_cause_e;

  localparam int NUM_EVT  = 5;
  localparam int NUM_LINT = 2;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stp,
  input  logic      slp,
  input  logic      snp,
  input  logic      snp_done,
  input  logic      all_sg,
  output pm_state_e state,
  output logic      slp_first
);
  pm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_NORM: if (stp) nxt = ST_SGNT;
      ST_SGNT: begin
        if (!stp)                nxt = ST_NORM;
        else if (snp)            nxt = ST_GSNP;
        else if (slp && all_sg)  nxt = ST_SLP;
      end
      ST_GSNP: if (snp_done) nxt = ST_SGNT;
      ST_SLP:  if (!slp)     nxt = ST_SGNT;
      default: nxt = ST_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= stp ? ST_SGNT : ST_NORM;
      slp_first <= 1'b0;
    end else begin
      state     <= nxt;
      slp_first <= (state == ST_SGNT) && (nxt == ST_SLP);
    end
  end

  // R2: stop request from Normal enters Stop-Grant
  p_norm_to_sg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM && stp) |=> (state == ST_SGNT));
  // R3: Grant-Snoop held until completion
  p_gs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GSNP && !snp_done) |=> (state == ST_GSNP));
  // R4: Sleep reachable only from Stop-Grant
  p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SGNT && state != ST_SLP) |=> (state != ST_SLP));
endmodule

// File: rtl/pmc_viol.sv
module pmc_viol
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pm_state_e  state,
  input  logic       stp,
  input  logic       slp,
  input  logic       snp,
  input  logic       all_sg,
  input  logic       slp_first,
  output logic       err,
  output err_cause_e err_cause
);
  err_cause_e cause;
  logic snp_bad, exit_bad, short_bad, place_bad;

  always_comb begin
    snp_bad   = (state == ST_SLP && snp) || (state == ST_SGNT && snp && slp);
    exit_bad  = (state == ST_SLP) && !stp;
    short_bad = (state == ST_SLP) && slp_first && !slp;
    place_bad = slp && ((state == ST_NORM) || (state == ST_GSNP) ||
                        (state == ST_SGNT && !all_sg));
    if (snp_bad)        cause = EC_SNP_SLEEP;
    else if (exit_bad)  cause = EC_EXIT_ORDER;
    else if (short_bad) cause = EC_SLP_SHORT;
    else if (place_bad) cause = EC_SLP_STATE;
    else                cause = EC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err       <= 1'b0;
      err_cause <= EC_NONE;
    end else begin
      err       <= (cause != EC_NONE);
      err_cause <= cause;
    end
  end

  // R5: sleep request in Normal is flagged
  p_slp_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM && slp) |=> (err && err_cause == EC_SLP_STATE));
  // R8: snoop during Sleep is flagged
  p_snoop_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && snp) |=> (err_cause == EC_SNP_SLEEP));
  // R7: stop-clock release while asleep
  p_exit_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && !stp && !snp) |=> (err_cause == EC_EXIT_ORDER));
endmodule

// File: rtl/pmc_evt.sv
module pmc_evt #(
  parameter int NUM_EVT  = 5,
  parameter int NUM_LINT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_norm,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic               intr_set,
  input  logic               int_en,
  output logic [NUM_EVT-1:0] svc,
  output logic               svc_intr,
  output logic               pbe_n
);
  localparam logic [NUM_EVT-1:0] LINT_MASK = NUM_EVT'((1 << NUM_LINT) - 1);

  logic [NUM_EVT-1:0] lat, grant, drain;
  logic               lat_intr, intr_go;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_pri
    if (i == NUM_EVT - 1) begin : g_top
      assign grant[i] = lat[i];
    end else begin : g_low
      assign grant[i] = lat[i] & ~(|lat[NUM_EVT-1:i+1]);
    end
  end

  assign drain   = is_norm ? grant : '0;
  assign intr_go = is_norm && int_en && lat_intr && (lat == '0);
  assign pbe_n   = !(lat_intr || |(lat & LINT_MASK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat      <= '0;
      svc      <= '0;
      lat_intr <= 1'b0;
      svc_intr <= 1'b0;
    end else begin
      lat      <= (lat & ~drain) | evt_req;
      svc      <= drain;
      lat_intr <= (lat_intr & ~intr_go) | intr_set;
      svc_intr <= intr_go;
    end
  end

  // R10: at most one service pulse per cycle
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({svc, svc_intr}));
  // R9: pulses only follow a Normal cycle
  p_norm_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|svc) || svc_intr) |-> $past(is_norm));
  // R11: a latched bus interrupt shows as a break event
  p_intr_pbe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    intr_set |=> !pbe_n);
  // R12: masked interrupt never serviced
  p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !svc_intr);
endmodule

// File: rtl/cstop_ctrl.sv
module cstop_ctrl
  import pmc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stpclk_n,
  input  logic                slp_n,
  input  logic                snoop_n,
  input  logic                snp_done,
  input  logic                bus_intr,
  input  logic                all_sg,
  input  logic                int_en,
  input  logic [NUM_EVT-1:0]  evt_req,
  output logic [NUM_EVT-1:0]  svc,
  output logic                svc_intr,
  output logic                pbe_n,
  output logic                err,
  output logic [2:0]          err_cause,
  output logic [1:0]          pm_state
);
  logic       stp, slp, snp, slp_first;
  pm_state_e  state;
  err_cause_e cause;

  assign stp = !stpclk_n;
  assign slp = !slp_n;
  assign snp = !snoop_n;

  pmc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stp(stp), .slp(slp), .snp(snp),
    .snp_done(snp_done), .all_sg(all_sg), .state(state), .slp_first(slp_first)
  );

  pmc_viol u_viol (
    .clk(clk), .rst_n(rst_n), .state(state), .stp(stp), .slp(slp), .snp(snp),
    .all_sg(all_sg), .slp_first(slp_first), .err(err), .err_cause(cause)
  );

  pmc_evt #(.NUM_EVT(NUM_EVT), .NUM_LINT(NUM_LINT)) u_evt (
    .clk(clk), .rst_n(rst_n), .is_norm(state == ST_NORM), .evt_req(evt_req),
    .intr_set((state == ST_GSNP) && snp_done && bus_intr), .int_en(int_en),
    .svc(svc), .svc_intr(svc_intr), .pbe_n(pbe_n)
  );

  assign err_cause = cause;
  assign pm_state  = state;
endmodule

// File: tb/sim_cstop_ctrl.sv
`timescale 1ns/1ps
module sim_cstop_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, stpclk_n, slp_n, snoop_n, snp_done, bus_intr, all_sg, int_en;
  logic [4:0] evt_req, svc;
  logic       svc_intr, pbe_n, err;
  logic [2:0] err_cause;
  logic [1:0] pm_state;

  cstop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n), .snoop_n(snoop_n),
    .snp_done(snp_done), .bus_intr(bus_intr), .all_sg(all_sg), .int_en(int_en),
    .evt_req(evt_req), .svc(svc), .svc_intr(svc_intr), .pbe_n(pbe_n), .err(err),
    .err_cause(err_cause), .pm_state(pm_state)
  );

  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  logic [1:0] m_st;
  logic       m_first, m_intr, m_svci, m_err;
  logic [4:0] m_lat, m_svc;
  logic [2:0] m_cause;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] next_state(logic [1:0] s, bit stp, bit slp, bit snp);
    logic [1:0] n = s;
    case (s)
      2'd0: if (stp) n = 2'd1;
      2'd1: if (!stp) n = 2'd0; else if (snp) n = 2'd2; else if (slp && all_sg) n = 2'd3;
      2'd2: if (snp_done) n = 2'd1;
      default: if (!slp) n = 2'd1;
    endcase
    return n;
  endfunction

  function automatic logic [2:0] exp_cause(logic [1:0] s, bit first, bit stp, bit slp, bit snp);
    logic [2:0] c = 3'd0;
    if (slp && (s == 2'd0 || s == 2'd2 || (s == 2'd1 && !all_sg))) c = 3'd1;
    if (s == 2'd3 && first && !slp) c = 3'd2;
    if (s == 2'd3 && !stp) c = 3'd3;
    if ((s == 2'd3 && snp) || (s == 2'd1 && snp && slp)) c = 3'd4;
    return c;
  endfunction

  task automatic model_step();
    bit stp, slp, snp, go, iset;
    logic [4:0] d;
    logic [1:0] ns;
    stp = !stpclk_n; slp = !slp_n; snp = !snoop_n;
    if (!rst_n) begin
      m_st = stp ? 2'd1 : 2'd0; m_first = 0; m_lat = 0; m_intr = 0;
      m_svc = 0; m_svci = 0; m_err = 0; m_cause = 0;
      return;
    end
    m_cause = exp_cause(m_st, m_first, stp, slp, snp);
    m_err   = (m_cause != 0);
    d = 5'd0;
    if (m_st == 2'd0)
      for (int i = 4; i >= 0; i--) if (m_lat[i] && d == 0) d[i] = 1'b1;
    go   = (m_st == 2'd0) && int_en && m_intr && (m_lat == 0);
    iset = (m_st == 2'd2) && snp_done && bus_intr;
    m_svc  = d;
    m_lat  = (m_lat & ~d) | evt_req;
    m_svci = go;
    m_intr = (m_intr & ~go) | iset;
    ns = next_state(m_st, stp, slp, snp);
    m_first = (m_st == 2'd1) && (ns == 2'd3);
    m_st = ns;
  endtask

  task automatic compare();
    chk(pm_state == m_st, "R2 state model", pm_state, m_st);
    chk(svc == m_svc, "R10 svc model", svc, m_svc);
    chk(svc_intr == m_svci, "R12 svc_intr model", svc_intr, m_svci);
    chk(pbe_n == !(m_lat[1] | m_lat[0] | m_intr), "R11 pbe_n model", pbe_n,
        !(m_lat[1] | m_lat[0] | m_intr));
    chk(err == m_err, "R13 err model", err, m_err);
    chk(err_cause == m_cause, "R8 cause model", err_cause, m_cause);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; stpclk_n = 1; slp_n = 1; snoop_n = 1; snp_done = 0; bus_intr = 0;
    all_sg = 1; int_en = 1; evt_req = 0;
    tick(); tick();
    // R1: reset state, stop-clock released
    chk(pm_state == 2'd0, "R1 reset to Normal", pm_state, 0);
    chk(pbe_n == 1'b1 && svc == 0 && err == 0, "R1 outputs cleared", {pbe_n, svc, err}, 7'b1000000);
    stpclk_n = 0; tick();
    chk(pm_state == 2'd1, "R1 reset holds Stop-Grant", pm_state, 1);
    rst_n = 1; tick();
    chk(pm_state == 2'd1, "R2 stays Stop-Grant", pm_state, 1);
    evt_req = 5'b10101; tick(); evt_req = 5'b00101; tick(); evt_req = 0; tick();
    chk(svc == 0, "R9 no service while stopped", svc, 0);
    snoop_n = 0; tick();
    chk(pm_state == 2'd2, "R3 snoop enters Grant-Snoop", pm_state, 2);
    snoop_n = 1; tick();
    chk(pm_state == 2'd2, "R3 held until done", pm_state, 2);
    snp_done = 1; bus_intr = 1; int_en = 0; tick();
    snp_done = 0; bus_intr = 0;
    chk(pm_state == 2'd1, "R3 back to Stop-Grant", pm_state, 1);
    chk(pbe_n == 1'b0, "R11 pending interrupt", pbe_n, 0);
    stpclk_n = 1; tick();
    chk(pm_state == 2'd0, "R2 release to Normal", pm_state, 0);
    tick(); chk(svc == 5'b10000, "R10 first pulse bus-init", svc, 16);
    tick(); chk(svc == 5'b00100, "R10 second pulse", svc, 4);
    tick(); chk(svc == 5'b00001, "R10 third pulse", svc, 1);
    tick(); chk(svc == 0, "R9 collapsed repeats", svc, 0);
    chk(svc_intr == 0, "R12 masked interrupt held", svc_intr, 0);
    chk(pbe_n == 0, "R11 masked still pending", pbe_n, 0);
    int_en = 1; tick();
    chk(svc_intr == 1, "R12 released when enabled", svc_intr, 1);
    tick(); chk(pbe_n == 1, "R11 cleared after service", pbe_n, 1);
    stpclk_n = 0; tick();
    slp_n = 0; all_sg = 0; tick();
    chk(pm_state == 2'd1 && err_cause == 3'd1, "R4 sleep without all threads",
        {pm_state, err_cause}, 5'b01001);
    all_sg = 1; tick();
    chk(pm_state == 2'd3 && err == 0, "R4 sleep entry", {pm_state, err}, 6);
    tick(); chk(err == 0, "R6 held sleep is legal", err, 0);
    slp_n = 1; tick();
    chk(pm_state == 2'd1 && err == 0, "R4 sleep exit", {pm_state, err}, 2);
    slp_n = 0; tick(); slp_n = 1; tick();
    chk(err_cause == 3'd2, "R6 short sleep", err_cause, 2);
    slp_n = 0; tick(); tick(); slp_n = 1; stpclk_n = 1; tick();
    chk(err_cause == 3'd3 && pm_state == 2'd1, "R7 exit order", {pm_state, err_cause}, 5'b01011);
    tick(); chk(pm_state == 2'd0 && err == 0, "R13 pulse ends", {pm_state, err}, 0);
    slp_n = 0; tick(); slp_n = 1;
    chk(err == 1 && err_cause == 3'd1, "R5 sleep in Normal", err_cause, 1);
    evt_req = 5'b10000; tick(); tick();
    chk(svc == 5'b10000, "R9 drain with re-arrival", svc, 16);
    evt_req = 0; tick();
    chk(svc == 5'b10000, "R9 re-latched pulse", svc, 16);
    tick(); chk(svc == 0, "R9 no third pulse", svc, 0);
    stpclk_n = 0; tick(); slp_n = 0; tick(); snoop_n = 0; tick();
    chk(err_cause == 3'd4 && pm_state == 2'd3, "R8 snoop in Sleep", {pm_state, err_cause}, 5'b11100);
    snoop_n = 1; slp_n = 1; tick();
    chk(err == 0, "R13 single cycle error", err, 0);
    for (int n = 0; n < 4000; n++) begin
      rst_n    = ($urandom % 100) >= 2;
      if (($urandom % 100) < 8)  stpclk_n = ~stpclk_n;
      if (($urandom % 100) < 10) slp_n = ~slp_n;
      snoop_n  = ($urandom % 100) >= 8;
      snp_done = ($urandom % 3) == 0;
      bus_intr = $urandom % 2;
      all_sg   = ($urandom % 10) != 0;
      int_en   = ($urandom % 4) != 0;
      for (int b = 0; b < 5; b++) evt_req[b] = ($urandom % 100) < 8;
      tick();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule